// File: doc/BRIEF.md
# Six-Master Five-Slave Bus Crossbar with Per-Port Arbitration

This block links six bus masters to five slave ports. Every slave port carries its own arbiter, so masters that address different slaves move their transfers in the same cycle, and up to five slaves can be busy at once. When several masters address the same slave, that port's arbiter picks one of them. The winner keeps the port until the slave signals ready. Every other requester of that port is stalled until then.

Each master uses a single-beat request handshake. It raises a request with an address, a write flag and write data, and holds them until it sees its ready pulse. The slave is chosen by the three top address bits. The slave port raises a valid strobe toward its slave, names the owning master, forwards that master's address, write flag and write data, and returns the slave's ready and read data to the owning master only.

Each slave port has its own 2-bit policy input that selects one of four modes: fixed priority, priority by programmed per-master levels, round-robin, or parking on a chosen default master. All arbitration happens in a port's idle cycle and is registered, so the grant appears one cycle after the request. A request from the parked master is the one exception: it is served in the same cycle.

Top module: `xbar_top`

## Requirements
- R1: The three top address bits select the slave port: values 0 to 4 select ports 0 to 4, and values 5, 6 and 7 are routed to port 0.
- R2: Masters addressing different slave ports are granted and completed in the same cycles, independently of each other.
- R3: A slave port grants at most one master at a time. While its slave holds ready low, the owner stays unchanged and every other requester of that port sees neither grant nor ready.
- R4: Policy code 0 (fixed priority): among the masters requesting an idle port, the lowest master index wins. The grant and valid strobe appear in the cycle after the request is first seen.
- R5: Policy code 1 (programmed priority): each master has a 3-bit level per port at bits [(port*6+master)*3 +: 3] of the priority input. The lowest level wins, and equal levels go to the lower master index.
- R6: Policy code 2 (round-robin): the search for a winner starts at the master index one above the last master granted on that port and wraps after 5. After reset the search starts at master 0.
- R7: Policy code 3 (parking): while the port is idle it presents the master named by its 3-bit park field. A request from that master is granted in the same cycle and beats any other requester. Other requests are served by fixed priority with the usual one-cycle delay.
- R8: A policy or parking change written while a port is owned does not alter the owner. The new setting governs only the arbitration after that transfer completes.
- R9: A master's ready and read data come from the slave port it addresses, and only while it owns that port. A slave port forwards the owner's address, write flag and write data.
- R10: During and right after reset, no slave valid strobe, master grant or master ready is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | 6 | Per-master request, held until ready |
| m_addr | input | 192 | Per-master address, 32 bits each |
| m_we | input | 6 | Per-master write flag |
| m_wdata | input | 192 | Per-master write data, 32 bits each |
| m_gnt | output | 6 | Master currently owns its addressed slave port |
| m_ready | output | 6 | Transfer of this master completes this cycle |
| m_rdata | output | 192 | Read data routed back to each master |
| s_valid | output | 5 | Per-slave transfer strobe |
| s_master | output | 15 | Per-slave owning (or parked) master index, 3 bits each |
| s_addr | output | 160 | Per-slave forwarded address |
| s_we | output | 5 | Per-slave forwarded write flag |
| s_wdata | output | 160 | Per-slave forwarded write data |
| s_ready | input | 5 | Per-slave completion |
| s_rdata | input | 160 | Per-slave read data |
| cfg_policy | input | 10 | Per-slave 2-bit policy code |
| cfg_prio | input | 90 | Per-slave, per-master 3-bit priority level |
| cfg_park | input | 15 | Per-slave 3-bit park master index |

## Verification
The bench targets out-of-range address selects. If these were not folded onto port 0, the request would reach no slave and hang. A stalled slave is used to confirm that ownership is held. A design that re-arbitrates each cycle would hand the port to a waiting master in the middle of a transfer. The round-robin pointer is checked over several consecutive grants, because an off-by-one pointer repeats or skips a master. Parking is checked for a same-cycle grant and for winning over a lower index. A mid-transfer switch to parking is checked as well: a design that applies the new mode at once would steal the port from its owner.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic [1:0] {
    MODE_FIXED = 2'd0,
    MODE_PROG  = 2'd1,
    MODE_RR    = 2'd2,
    MODE_PARK  = 2'd3
  } arb_mode_e;

  localparam int SEL_BITS = 3;

endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
  parameter int N_S = 5,
  parameter int SIW = 3
) (
  input  logic [xbar_pkg::SEL_BITS-1:0] sel_bits,
  output logic [SIW-1:0]                slave_idx
);

  function automatic logic [SIW-1:0] map_sel(input logic [xbar_pkg::SEL_BITS-1:0] s);
    if (int'(s) < N_S) return SIW'(s);
    return '0;
  endfunction

  assign slave_idx = map_sel(sel_bits);

endmodule

// File: rtl/xbar_port_arb.sv
module xbar_port_arb #(
  parameter int N_M = 6,
  parameter int PW  = 3,
  parameter int IW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_M-1:0]    req,
  input  logic [1:0]        mode,
  input  logic [N_M*PW-1:0] prio,
  input  logic [IW-1:0]     park_id,
  input  logic              s_ready,
  output logic              s_valid,
  output logic [IW-1:0]     owner,
  output logic [N_M-1:0]    grant,
  output logic              locked
);
  import xbar_pkg::*;

  logic [IW-1:0] owner_q, last_q, win;
  logic          park_hit, any_req;
  arb_mode_e     cur_mode;

  function automatic logic [IW-1:0] pick_fixed(input logic [N_M-1:0] r);
    logic [IW-1:0] w;
    w = '0;
    for (int i = N_M - 1; i >= 0; i--)
      if (r[i]) w = IW'(i);
    return w;
  endfunction

  function automatic logic [IW-1:0] pick_prog(input logic [N_M-1:0] r,
                                              input logic [N_M*PW-1:0] p);
    logic [IW-1:0] w;
    logic [PW:0]   best;
    w    = '0;
    best = {1'b1, {PW{1'b0}}};
    for (int i = 0; i < N_M; i++)
      if (r[i] && ({1'b0, p[i*PW +: PW]} < best)) begin
        best = {1'b0, p[i*PW +: PW]};
        w    = IW'(i);
      end
    return w;
  endfunction

  function automatic logic [IW-1:0] pick_rr(input logic [N_M-1:0] r,
                                            input logic [IW-1:0] last);
    logic [IW-1:0] w;
    logic          found;
    int            idx;
    w     = '0;
    found = 1'b0;
    for (int k = 1; k <= N_M; k++) begin
      idx = int'(last) + k;
      if (idx >= N_M) idx = idx - N_M;
      if (!found && r[idx]) begin
        found = 1'b1;
        w     = IW'(idx);
      end
    end
    return w;
  endfunction

  assign cur_mode = arb_mode_e'(mode);
  assign any_req  = |req;
  assign park_hit = (cur_mode == MODE_PARK) && (int'(park_id) < N_M) &&
                    req[park_id];

  always_comb begin
    unique case (cur_mode)
      MODE_PROG: win = pick_prog(req, prio);
      MODE_RR:   win = pick_rr(req, last_q);
      default:   win = pick_fixed(req);
    endcase
  end

  always_comb begin
    if (locked) begin
      s_valid = 1'b1;
      owner   = owner_q;
    end else if (park_hit) begin
      s_valid = 1'b1;
      owner   = park_id;
    end else begin
      s_valid = 1'b0;
      owner   = (cur_mode == MODE_PARK) ? park_id : owner_q;
    end
  end

  always_comb begin
    grant = '0;
    for (int i = 0; i < N_M; i++)
      if (s_valid && owner == IW'(i)) grant[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      owner_q <= '0;
      last_q  <= IW'(N_M - 1);
    end else if (locked) begin
      if (s_ready) locked <= 1'b0;
    end else if (park_hit) begin
      last_q <= park_id;
      if (!s_ready) begin
        locked  <= 1'b1;
        owner_q <= park_id;
      end
    end else if (any_req) begin
      locked  <= 1'b1;
      owner_q <= win;
      last_q  <= win;
    end
  end

endmodule

// File: rtl/xbar_top.sv
module xbar_top #(
  parameter int N_M = 6,
  parameter int N_S = 5,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int PW  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_M-1:0]      m_req,
  input  logic [N_M*AW-1:0]   m_addr,
  input  logic [N_M-1:0]      m_we,
  input  logic [N_M*DW-1:0]   m_wdata,
  output logic [N_M-1:0]      m_gnt,
  output logic [N_M-1:0]      m_ready,
  output logic [N_M*DW-1:0]   m_rdata,
  output logic [N_S-1:0]      s_valid,
  output logic [N_S*3-1:0]    s_master,
  output logic [N_S*AW-1:0]   s_addr,
  output logic [N_S-1:0]      s_we,
  output logic [N_S*DW-1:0]   s_wdata,
  input  logic [N_S-1:0]      s_ready,
  input  logic [N_S*DW-1:0]   s_rdata,
  input  logic [N_S*2-1:0]    cfg_policy,
  input  logic [N_S*N_M*PW-1:0] cfg_prio,
  input  logic [N_S*3-1:0]    cfg_park
);
  import xbar_pkg::*;

  localparam int IW  = 3;
  localparam int SIW = $clog2(N_S);

  logic [N_M-1:0][SIW-1:0] m_dest;
  logic [N_S-1:0][N_M-1:0] req_m2s;
  logic [N_S-1:0][N_M-1:0] gnt_m2s;
  logic [N_S-1:0][IW-1:0]  owner;
  logic [N_S-1:0]          arb_locked;

  for (genvar i = 0; i < N_M; i++) begin : g_dec
    xbar_decode #(.N_S(N_S), .SIW(SIW)) u_dec (
      .sel_bits (m_addr[i*AW + AW - SEL_BITS +: SEL_BITS]),
      .slave_idx(m_dest[i])
    );
  end

  always_comb begin
    for (int j = 0; j < N_S; j++)
      for (int i = 0; i < N_M; i++)
        req_m2s[j][i] = m_req[i] && (m_dest[i] == SIW'(j));
  end

  for (genvar j = 0; j < N_S; j++) begin : g_port
    xbar_port_arb #(.N_M(N_M), .PW(PW), .IW(IW)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req_m2s[j]),
      .mode   (cfg_policy[j*2 +: 2]),
      .prio   (cfg_prio[j*N_M*PW +: N_M*PW]),
      .park_id(cfg_park[j*IW +: IW]),
      .s_ready(s_ready[j]),
      .s_valid(s_valid[j]),
      .owner  (owner[j]),
      .grant  (gnt_m2s[j]),
      .locked (arb_locked[j])
    );

    assign s_master[j*IW +: IW] = owner[j];

    always_comb begin
      s_addr[j*AW +: AW]  = '0;
      s_we[j]             = 1'b0;
      s_wdata[j*DW +: DW] = '0;
      for (int i = 0; i < N_M; i++)
        if (owner[j] == IW'(i)) begin
          s_addr[j*AW +: AW]  = m_addr[i*AW +: AW];
          s_we[j]             = m_we[i];
          s_wdata[j*DW +: DW] = m_wdata[i*DW +: DW];
        end
    end
  end

  always_comb begin
    for (int i = 0; i < N_M; i++) begin
      m_gnt[i]            = 1'b0;
      m_ready[i]          = 1'b0;
      m_rdata[i*DW +: DW] = '0;
      for (int j = 0; j < N_S; j++) begin
        if (gnt_m2s[j][i]) m_gnt[i] = 1'b1;
        if (m_dest[i] == SIW'(j)) begin
          m_ready[i]          = gnt_m2s[j][i] && s_ready[j];
          m_rdata[i*DW +: DW] = s_rdata[j*DW +: DW];
        end
      end
    end
  end

endmodule

// File: rtl/xbar_sva.sv
module xbar_sva #(
  parameter int N_M = 6,
  parameter int N_S = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_M-1:0]         m_gnt,
  input logic [N_M-1:0]         m_ready,
  input logic [N_S-1:0]         s_valid,
  input logic [N_S*3-1:0]       s_master,
  input logic [N_S-1:0]         s_ready,
  input logic [N_S*2-1:0]       cfg_policy,
  input logic [N_S*3-1:0]       cfg_park,
  input logic [N_S-1:0]         arb_locked,
  input logic [N_S-1:0][N_M-1:0] req_m2s,
  input logic [N_S-1:0][N_M-1:0] gnt_m2s
);

  for (genvar j = 0; j < N_S; j++) begin : g_chk
    // R3: one owner per slave port
    a_r3_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_m2s[j]));

    // R3: owner held while the slave stalls
    a_r3_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_locked[j] && !s_ready[j]) |=> (s_valid[j] && $stable(s_master[j*3 +: 3])));

    // R4: an idle port with requests and no immediate grant serves next cycle
    a_r4_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (!arb_locked[j] && !s_valid[j] && (|req_m2s[j])) |=> s_valid[j]);

    // R7: parked master served in the same cycle
    a_r7_park_now: assert property (@(posedge clk) disable iff (!rst_n)
      (!arb_locked[j] && cfg_policy[j*2 +: 2] == 2'd3 && int'(cfg_park[j*3 +: 3]) < N_M &&
       req_m2s[j][cfg_park[j*3 +: 3]])
      |-> (s_valid[j] && s_master[j*3 +: 3] == cfg_park[j*3 +: 3]));
  end

  for (genvar i = 0; i < N_M; i++) begin : g_mchk
    // R9: ready only reaches an owning master
    a_r9_ready_owner: assert property (@(posedge clk) disable iff (!rst_n)
      m_ready[i] |-> m_gnt[i]);
  end

  // R10: nothing active while reset is held
  always @(posedge clk)
    if (!rst_n) a_r10_reset_quiet: assert (s_valid == '0 && m_gnt == '0);

endmodule

bind xbar_top xbar_sva #(.N_M(N_M), .N_S(N_S)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .m_gnt     (m_gnt),
  .m_ready   (m_ready),
  .s_valid   (s_valid),
  .s_master  (s_master),
  .s_ready   (s_ready),
  .cfg_policy(cfg_policy),
  .cfg_park  (cfg_park),
  .arb_locked(arb_locked),
  .req_m2s   (req_m2s),
  .gnt_m2s   (gnt_m2s)
);

// File: tb/tb_xbar_top.sv
module tb_xbar_top;
  localparam int NM = 6, NS = 5, AW = 32, DW = 32, PW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NM-1:0] m_req = '0, m_we = '0, m_gnt, m_ready;
  logic [NM*AW-1:0] m_addr = '0;
  logic [NM*DW-1:0] m_wdata = '0, m_rdata;
  logic [NS-1:0] s_valid, s_we, s_ready = '1;
  logic [NS*3-1:0] s_master;
  logic [NS*AW-1:0] s_addr;
  logic [NS*DW-1:0] s_wdata, s_rdata;
  logic [NS*2-1:0] cfg_policy = '0;
  logic [NS*NM*PW-1:0] cfg_prio = '1;
  logic [NS*3-1:0] cfg_park = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  for (genvar j = 0; j < NS; j++) begin : g_rd
    assign s_rdata[j*DW +: DW] = 32'hA000_0000 + j;
  end

  xbar_top dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int m, input int sel, input bit we, input logic [31:0] d);
    m_addr[m*AW +: AW]  = {sel[2:0], 29'(m * 16)};
    m_we[m]             = we;
    m_wdata[m*DW +: DW] = d;
    m_req[m]            = 1'b1;
  endtask

  function automatic int owner_of(input int j);
    return int'(s_master[j*3 +: 3]);
  endfunction

  task automatic wait_grant(input int j, output int who);
    who = -1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      if (s_valid[j]) begin who = owner_of(j); return; end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(s_valid == '0 && m_gnt == '0 && m_ready == '0, "R10 reset quiet", s_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_valid == '0 && m_gnt == '0, "R10 after reset", s_valid, 0);
  endtask

  task automatic t_decode;
    issue(2, 6, 1'b1, 32'h1234_5678);
    @(negedge clk); #1;
    chk(s_valid[0] && owner_of(0) == 2, "R1 sel 6 to port 0", owner_of(0), 2);
    chk(s_addr[0*AW +: AW] == m_addr[2*AW +: AW] && s_we[0] && s_wdata[0*DW +: DW] == 32'h1234_5678,
        "R9 forward fields", s_wdata[0*DW +: DW], 32'h1234_5678);
    chk(m_ready[2] && m_rdata[2*DW +: DW] == 32'hA000_0000, "R9 read data", m_rdata[2*DW +: DW], 32'hA000_0000);
    m_req = '0;
    @(negedge clk);
  endtask

  task automatic t_parallel;
    issue(0, 3, 1'b0, 0);
    issue(1, 4, 1'b0, 0);
    @(negedge clk); #1;
    chk(m_gnt[0] && m_gnt[1], "R2 both granted", m_gnt, 3);
    chk(m_ready[1] && m_rdata[1*DW +: DW] == 32'hA000_0004, "R2 R9 port4 data", m_rdata[1*DW +: DW], 32'hA000_0004);
    m_req = '0;
    @(negedge clk);
  endtask

  task automatic t_fixed_stall;
    int who;
    s_ready[0] = 1'b0;
    issue(3, 0, 0, 0); issue(1, 0, 0, 0); issue(5, 0, 0, 0);
    #1;
    chk(!s_valid[0], "R4 no grant in request cycle", s_valid[0], 0);
    wait_grant(0, who);
    chk(who == 1, "R4 lowest index wins", who, 1);
    repeat (3) @(negedge clk);
    #1;
    chk(owner_of(0) == 1 && !m_gnt[3] && !m_gnt[5] && m_ready == '0, "R3 stall holds owner",
        owner_of(0), 1);
    s_ready[0] = 1'b1;
    #1;
    chk(m_ready == 6'b000010, "R3 only owner ready", m_ready, 2);
    m_req[1] = 1'b0;
    @(negedge clk);
    wait_grant(0, who);
    chk(who == 3, "R4 next lowest after release", who, 3);
    m_req = '0;
    @(negedge clk);
  endtask

  task automatic t_prog;
    int who;
    cfg_policy[3*2 +: 2] = 2'd1;
    cfg_prio[(3*NM+5)*PW +: PW] = 3'd0;
    cfg_prio[(3*NM+1)*PW +: PW] = 3'd2;
    issue(1, 3, 0, 0); issue(5, 3, 0, 0);
    wait_grant(3, who);
    chk(who == 5, "R5 lowest level wins", who, 5);
    m_req = '0;
    @(negedge clk);
    cfg_prio[(3*NM+4)*PW +: PW] = 3'd2;
    issue(4, 3, 0, 0); issue(1, 3, 0, 0);
    wait_grant(3, who);
    chk(who == 1, "R5 tie to lower index", who, 1);
    m_req = '0;
    @(negedge clk);
  endtask

  task automatic t_rr;
    int who;
    int exp_seq[4] = '{0, 2, 4, 0};
    cfg_policy[1*2 +: 2] = 2'd2;
    issue(0, 1, 0, 0); issue(2, 1, 0, 0); issue(4, 1, 0, 0);
    for (int k = 0; k < 4; k++) begin
      wait_grant(1, who);
      chk(who == exp_seq[k], "R6 rotation order", who, exp_seq[k]);
    end
    m_req = '0;
    @(negedge clk);
  endtask

  task automatic t_park;
    int who;
    cfg_policy[2*2 +: 2] = 2'd3;
    cfg_park[2*3 +: 3] = 3'd3;
    @(negedge clk); #1;
    chk(!s_valid[2] && owner_of(2) == 3, "R7 idle parked", owner_of(2), 3);
    issue(1, 2, 0, 0); issue(3, 2, 0, 0);
    #1;
    chk(s_valid[2] && owner_of(2) == 3 && m_ready[3], "R7 same-cycle park grant", owner_of(2), 3);
    @(negedge clk);
    m_req[3] = 1'b0;
    wait_grant(2, who);
    chk(who == 1, "R7 others after parked", who, 1);
    m_req = '0;
    @(negedge clk);
  endtask

  task automatic t_cfg_mid;
    int who;
    s_ready[4] = 1'b0;
    issue(3, 4, 0, 0);
    wait_grant(4, who);
    chk(who == 3, "R8 initial owner", who, 3);
    cfg_policy[4*2 +: 2] = 2'd3;
    cfg_park[4*3 +: 3] = 3'd0;
    issue(0, 4, 0, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(owner_of(4) == 3 && !m_gnt[0], "R8 owner kept after mode change", owner_of(4), 3);
    s_ready[4] = 1'b1;
    #1;
    chk(m_ready[3], "R8 owner completes", m_ready[3], 1);
    m_req[3] = 1'b0;
    @(negedge clk); #1;
    chk(s_valid[4] && owner_of(4) == 0, "R8 new mode after completion", owner_of(4), 0);
    m_req = '0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_parallel();
    t_fixed_stall();
    t_prog();
    t_rr();
    t_park();
    t_cfg_mid();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule